// File: doc/BRIEF.md
# Interrupt Register with AND/OR Aliases

This block holds one 64-bit control word on a simple doubleword register bus, and only its upper sixteen bits are implemented. Software reaches the word through three neighbouring doubleword offsets. The first offset replaces the value and can be read back. The second offset clears bits atomically: the new value is the old value ANDed with the write data. The third offset sets bits atomically: the new value is the old value ORed with the write data. The most significant bit of the word drives a level interrupt toward an interrupt controller. Software raises that interrupt by setting the bit and lowers it by clearing the bit.

The bus accepts a request in every cycle, and a write takes effect at the clock edge that accepts it. Every request gets a response one cycle later. Read data and an error flag come back with that response. A request that is not a whole, aligned doubleword is refused: it gets the error flag and leaves the word alone. The bus carries the data as one doubleword, with bit 63 as the most significant bit.

Top module: `alias_irq_reg`

## Requirements
- R1: The register offset is the byte address shifted right by 3. A write to offset 0x4020 replaces the stored value, and a read of 0x4020 returns the stored value.
- R2: A write to offset 0x4021 stores the old value ANDed with the write data.
- R3: A write to offset 0x4022 stores the old value ORed with the write data.
- R4: Only bits 63..48 are kept after any write. Bits 47..0 always read back as zero, whatever was written.
- R5: `irq` equals bit 63 of the stored value. It changes in the cycle after the write that changes that bit, so clearing bit 63 drops it.
- R6: A well-formed read of any offset other than 0x4020 returns zero without an error, and this includes 0x4021 and 0x4022.
- R7: A well-formed write to any offset other than 0x4020, 0x4021 or 0x4022 leaves the stored value unchanged.
- R8: A request is refused when byte address bits 2..0 are not zero or when `req_size` is not 8. A refused request returns `rsp_err`=1 with zero data and leaves the stored value unchanged.
- R9: `req_ready` is always 1. Each accepted request produces `rsp_valid`=1 in exactly the next cycle, carrying its data and error flag.
- R10: After reset the stored value is zero, `irq` is 0 and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data, bit 63 most significant |
| rsp_valid | output | 1 | Response present, one cycle after request |
| rsp_err | output | 1 | Request refused (misaligned or wrong size) |
| rsp_rdata | output | 64 | Read data |
| irq | output | 1 | Level interrupt, bit 63 of the stored value |

## Verification
The assertions check the following on every cycle:
- a response follows each request;
- refused responses carry zero data;
- an OR write with bit 63 set raises the interrupt;
- an AND write with bit 63 clear lowers the interrupt;
- a cycle without a decoded write leaves the stored bits untouched.

Only the bench scenarios show the full merge results of the three aliases, the zeroed low field, the zero reads of the other offsets, and that unknown offsets and malformed requests have no effect. The bench observes these through read-back of the direct offset.

// File: rtl/alias_irq_reg_pkg.sv
package alias_irq_reg_pkg;
  typedef enum logic [1:0] {
    WR_NONE = 2'd0,
    WR_SET  = 2'd1,
    WR_AND  = 2'd2,
    WR_OR   = 2'd3
  } wr_mode_e;
endpackage

// File: rtl/alias_irq_decode.sv
module alias_irq_decode
  import alias_irq_reg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 4,
  parameter int BYTES   = 8,
  parameter int OFS_SET = 'h4020,
  parameter int OFS_AND = 'h4021,
  parameter int OFS_OR  = 'h4022
) (
  input  logic              valid_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              shape_ok_o,
  output wr_mode_e          mode_o,
  output logic              rd_hit_o
);
  localparam int LSB_W = $clog2(BYTES);
  localparam int OFS_W = ADDR_W - LSB_W;

  logic [OFS_W-1:0] offset;

  assign offset     = addr_i[ADDR_W-1:LSB_W];
  assign shape_ok_o = (addr_i[LSB_W-1:0] == '0) && (size_i == SIZE_W'(BYTES));

  always_comb begin
    mode_o = WR_NONE;
    if (valid_i && write_i && shape_ok_o) begin
      if (offset == OFS_W'(OFS_SET))      mode_o = WR_SET;
      else if (offset == OFS_W'(OFS_AND)) mode_o = WR_AND;
      else if (offset == OFS_W'(OFS_OR))  mode_o = WR_OR;
    end
  end

  assign rd_hit_o = valid_i && !write_i && shape_ok_o && (offset == OFS_W'(OFS_SET));
endmodule

// File: rtl/alias_irq_store.sv
module alias_irq_store
  import alias_irq_reg_pkg::*;
#(
  parameter int KEEP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_mode_e          mode_i,
  input  logic [KEEP_W-1:0] wdata_i,
  output logic [KEEP_W-1:0] value_o,
  output logic              irq_o
);
  logic [KEEP_W-1:0] value_q;
  logic [KEEP_W-1:0] value_d;

  function automatic logic [KEEP_W-1:0] merge(wr_mode_e m, logic [KEEP_W-1:0] cur,
                                              logic [KEEP_W-1:0] din);
    case (m)
      WR_SET:  return din;
      WR_AND:  return cur & din;
      WR_OR:   return cur | din;
      default: return cur;
    endcase
  endfunction

  assign value_d = merge(mode_i, value_q, wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value_q <= '0;
    else        value_q <= value_d;
  end

  assign value_o = value_q;
  assign irq_o   = value_q[KEEP_W-1];

  // R3: OR alias with the top bit set must raise the interrupt
  p_or_raises_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == WR_OR && wdata_i[KEEP_W-1]) |=> irq_o);
  // R2: AND alias with the top bit clear must drop the interrupt
  p_and_drops_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == WR_AND && !wdata_i[KEEP_W-1]) |=> !irq_o);
  // R7: no decoded write means no change
  p_idle_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == WR_NONE) |=> $stable(value_q));
endmodule

// File: rtl/alias_irq_reg.sv
module alias_irq_reg
  import alias_irq_reg_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int SIZE_W  = 4,
  parameter int DATA_W  = 64,
  parameter int KEEP_W  = 16,
  parameter int OFS_SET = 'h4020,
  parameter int OFS_AND = 'h4021,
  parameter int OFS_OR  = 'h4022
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              irq
);
  localparam int BYTES  = DATA_W / 8;
  localparam int LOW_W  = DATA_W - KEEP_W;

  logic              shape_ok;
  logic              rd_hit;
  wr_mode_e          wr_mode;
  logic [KEEP_W-1:0] value;

  alias_irq_decode #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .BYTES(BYTES),
    .OFS_SET(OFS_SET), .OFS_AND(OFS_AND), .OFS_OR(OFS_OR)
  ) u_decode (
    .valid_i   (req_valid),
    .write_i   (req_write),
    .addr_i    (req_addr),
    .size_i    (req_size),
    .shape_ok_o(shape_ok),
    .mode_o    (wr_mode),
    .rd_hit_o  (rd_hit)
  );

  alias_irq_store #(.KEEP_W(KEEP_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (wr_mode),
    .wdata_i(req_wdata[DATA_W-1 -: KEEP_W]),
    .value_o(value),
    .irq_o  (irq)
  );

  assign req_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !shape_ok;
      rsp_rdata <= rd_hit ? {value, {LOW_W{1'b0}}} : '0;
    end
  end

  // R9: every request gets a response in the next cycle
  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R8: a refused request carries no data
  p_err_no_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
  // R8: a malformed request never changes the interrupt level
  p_err_keeps_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !shape_ok) |=> $stable(irq));
endmodule

// File: tb/alias_irq_reg_tb.sv
module alias_irq_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_err;
  logic [63:0] rsp_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;
  logic [15:0] model = '0;

  localparam int A_SET = 'h4020;
  localparam int A_AND = 'h4021;
  localparam int A_OR  = 'h4022;

  always #5 clk = ~clk;

  alias_irq_reg u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample the registered response at the following negedge
  task automatic access(input bit wr, input logic [31:0] addr, input logic [3:0] size,
                        input logic [63:0] data, output logic [63:0] rd,
                        output logic err, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_size = size; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    rd = rsp_rdata; err = rsp_err; rv = rsp_valid;
  endtask

  task automatic read_direct(input string tag);
    logic [63:0] rd; logic err, rv;
    access(1'b0, A_SET << 3, 4'd8, '0, rd, err, rv);
    check(rv && !err && rd == {model, 48'h0}, tag, rd, {model, 48'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] rd; logic err, rv;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(irq == 1'b0 && rsp_valid == 1'b0, "R10 reset outputs", {rsp_valid, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 ready high", req_ready, 1);
    read_direct("R10 reset value");

    // R1 R2 R3 R4 R5: sweep of patterns over the three write aliases
    for (int i = 0; i < 30; i++) begin
      logic [15:0] p;
      logic [63:0] w;
      int op;
      p  = 16'(i * 40503 + 7 * i + 3);
      w  = {p, 48'hFFFF_FFFF_FFFF ^ 48'(i)};
      op = i % 3;
      access(1'b1, (A_SET + op) << 3, 4'd8, w, rd, err, rv);
      case (op)
        0: model = p;
        1: model = model & p;
        default: model = model | p;
      endcase
      check(rv && !err, "R9 write response", {rv, err}, 2'b10);
      check(irq == model[15], "R5 irq tracks bit 63", irq, model[15]);
      read_direct(op == 0 ? "R1 direct write/R4 low zero" :
                  op == 1 ? "R2 AND alias" : "R3 OR alias");
      // R6: aliases read as zero
      access(1'b0, A_AND << 3, 4'd8, '0, rd, err, rv);
      check(rv && !err && rd == 0, "R6 AND alias reads zero", rd, 0);
      access(1'b0, A_OR << 3, 4'd8, '0, rd, err, rv);
      check(rv && !err && rd == 0, "R6 OR alias reads zero", rd, 0);
    end

    // R5: explicit raise and drop through aliases
    access(1'b1, A_OR << 3, 4'd8, 64'h8000_0000_0000_0000, rd, err, rv);
    model = model | 16'h8000;
    check(irq == 1'b1, "R5 OR raises irq", irq, 1);
    access(1'b1, A_AND << 3, 4'd8, 64'h7FFF_FFFF_FFFF_FFFF, rd, err, rv);
    model = model & 16'h7FFF;
    check(irq == 1'b0, "R5 AND drops irq", irq, 0);
    read_direct("R5 value after drop");

    // R6 R7: unknown offsets around the block
    access(1'b1, A_SET << 3, 4'd8, 64'h5A5A_0000_0000_0000, rd, err, rv);
    model = 16'h5A5A;
    for (int o = 'h401C; o <= 'h4026; o++) begin
      if (o >= A_SET && o <= A_OR) continue;
      access(1'b1, o << 3, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, rd, err, rv);
      check(rv && !err && irq == 1'b0, "R7 unknown write no irq", irq, 0);
      read_direct("R7 unknown write no effect");
      access(1'b0, o << 3, 4'd8, '0, rd, err, rv);
      check(rv && !err && rd == 0, "R6 unknown read zero", rd, 0);
    end

    // R8: misaligned addresses
    for (int b = 1; b < 8; b++) begin
      access(1'b1, (A_SET << 3) + b, 4'd8, 64'hFFFF_0000_0000_0000, rd, err, rv);
      check(rv && err, "R8 misaligned write err", err, 1);
      read_direct("R8 misaligned write no effect");
      access(1'b0, (A_SET << 3) + b, 4'd8, '0, rd, err, rv);
      check(rv && err && rd == 0, "R8 misaligned read err zero", rd, 0);
    end
    // R8: every wrong size
    for (int s = 0; s < 16; s++) begin
      if (s == 8) continue;
      access(1'b1, A_OR << 3, 4'(s), 64'hFFFF_0000_0000_0000, rd, err, rv);
      check(rv && err && irq == 1'b0, "R8 bad size write err", {err, irq}, 2'b10);
      read_direct("R8 bad size no effect");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule